// File: doc/BRIEF.md
# Sleep-State Handshake Controller

This block is the chip-side power sequencer that talks to the board's power logic through a small set of active-low sleep indications and a few power-good inputs. When asked to power down, it drops every output to its asserted (low) level and rests in soft-off. When asked to wake, it first releases the deep-sleep indication. It then waits for the board to report good DRAM I/O power on both memory channels. It passes through the suspend-to-RAM state for exactly one cycle, because that state is not supported as a resting place. Leaving that state releases the suspend-to-RAM and DRAM-termination indications together. It then waits for core power-good, and finally releases the suspend status and the platform reset.

The internal core reset also drives a debug CPU reset output, so that output releases on the same edge as the platform reset. Every power-good input crosses into the controller's clock domain through a two-stage synchroniser before the state machine sees it. A loss of DRAM power while fully on sends the controller straight back to soft-off. A state code is brought out for observation.

Top module: `sleep_seq_ctrl`

## Requirements
- R1: While the synchronous active-low reset is low, and on the cycle it releases, every output is low and the state code is 0.
- R2: In soft-off, a wake request moves the controller to waiting-for-DRAM-power on the next edge and raises the deep-sleep output. A soft-off request on the same cycle wins, and the controller stays in soft-off.
- R3: Waiting-for-DRAM-power is held until both DRAM power-good inputs, as seen after synchronisation, are high. One channel alone does not advance the state.
- R4: The suspend-to-RAM state lasts exactly one cycle and is followed by waiting-for-core-power, unless a soft-off request is present.
- R5: The suspend-to-RAM sleep output and the DRAM-termination sleep output rise on the same edge, the one that enters waiting-for-core-power.
- R6: With synchronised core power-good high in waiting-for-core-power, the next edge enters full-on and raises both the suspend status output and the platform reset output.
- R7: The debug CPU reset output always equals the platform reset output.
- R8: A power-good input change is first acted on at the third rising edge after it is applied (two synchroniser stages plus the state register).
- R9: A soft-off request in any state other than soft-off returns the controller to soft-off on the next edge, with all outputs low.
- R10: In full-on, a low on either synchronised DRAM power-good input returns the controller to soft-off on the next edge, with all outputs low.
- R11: The state code reads 0 for soft-off, 1 for waiting-for-DRAM-power, 2 for suspend-to-RAM, 3 for waiting-for-core-power and 4 for full-on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low cold reset |
| soft_off_req | input | 1 | Request to enter soft-off |
| wake_req | input | 1 | Request to leave soft-off |
| dram_pg | input | DRAM_CH | DRAM I/O power-good, one bit per channel, asynchronous |
| core_pg | input | 1 | Core power-good, asynchronous |
| deep_sleep_n | output | 1 | Deep-sleep indication, low = asserted |
| s2r_sleep_n | output | 1 | Suspend-to-RAM indication, low = asserted |
| dram_term_sleep_n | output | 1 | DRAM termination-off indication, low = asserted |
| susp_stat_n | output | 1 | Suspend status, low = asserted |
| plat_rst_n | output | 1 | Platform reset, low = asserted |
| dbg_cpu_rst_n | output | 1 | Debug CPU reset, low = asserted |
| state_o | output | 3 | Current state code (R11) |

## Verification
The hardest condition to reach from the ports is the one-cycle stay in suspend-to-RAM. Its timing depends on when the synchronised DRAM power-good bits line up, so the stimulus raises one channel and holds it long enough to show that nothing advances. It then raises the second channel and samples on each of the next three cycles, which shows both the synchroniser latency and the single-cycle pass. A second wake, with power-good already stable, reaches suspend-to-RAM straight from waiting-for-DRAM-power. Soft-off requests are then injected in the waiting states and in full-on to cover each exit path.

// File: rtl/sleep_seq_pkg.sv
// Package: shared state type and widths for the sleep-state controller.
// Assumes: state codes are observable at the top and must keep these values.
package sleep_seq_pkg;

    localparam int STATE_W = 3;

    typedef enum logic [STATE_W-1:0] {
        ST_OFF       = 3'd0,
        ST_WAIT_DRAM = 3'd1,
        ST_S2R       = 3'd2,
        ST_WAIT_CORE = 3'd3,
        ST_ON        = 3'd4
    } pwr_state_t;

endpackage

// File: rtl/pg_sync.sv
// Module: multi-stage synchroniser for a vector of asynchronous level inputs.
// Assumes: each bit is a slow level signal, so the bits are synchronised independently;
//          reset clears every stage to 0 (power not good).
module pg_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stage [STAGES];

    // Shift each input through the chain of flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage[i] <= '0;
        end else begin
            stage[0] <= din;
            for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
        end
    end

    assign dout = stage[STAGES-1];

    generate
        if (STAGES >= 2) begin : g_chk
            // R8: the output only takes a value that the stage before it already held.
            p_sync_chain_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (dout != $past(dout)) |-> (dout == $past(stage[STAGES-2])));
        end
    endgenerate

endmodule

// File: rtl/sleep_seq_fsm.sv
// Module: power-state sequencer for soft-off down and full-on up.
// Assumes: dram_ok and core_ok are already synchronised; the soft-off request
//          has priority over every other event.
module sleep_seq_fsm
    import sleep_seq_pkg::*;
#(
    parameter int DRAM_CH = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               soft_off_req,
    input  logic               wake_req,
    input  logic [DRAM_CH-1:0] dram_ok,
    input  logic               core_ok,
    output pwr_state_t         state_q,
    output pwr_state_t         state_d
);

    logic dram_all_ok;
    assign dram_all_ok = &dram_ok;

    // Next-state decision.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_OFF:       if (!soft_off_req && wake_req) state_d = ST_WAIT_DRAM;
            ST_WAIT_DRAM: if (soft_off_req) state_d = ST_OFF;
                          else if (dram_all_ok) state_d = ST_S2R;
            ST_S2R:       state_d = soft_off_req ? ST_OFF : ST_WAIT_CORE;
            ST_WAIT_CORE: if (soft_off_req) state_d = ST_OFF;
                          else if (core_ok) state_d = ST_ON;
            ST_ON:        if (soft_off_req || !dram_all_ok) state_d = ST_OFF;
            default:      state_d = ST_OFF;
        endcase
    end

    // State register, cold reset into soft-off.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // R4: suspend-to-RAM is never held for a second cycle.
    p_s2r_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_S2R && !soft_off_req) |=> (state_q == ST_WAIT_CORE));

    // R3: one missing DRAM channel keeps the wait.
    p_hold_wait_dram_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_DRAM && !dram_all_ok && !soft_off_req) |=> (state_q == ST_WAIT_DRAM));

    // R9: a soft-off request always lands in soft-off.
    p_req_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_OFF && soft_off_req) |=> (state_q == ST_OFF));

    // R10: DRAM power loss while on drops to soft-off.
    p_dram_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ON && !dram_all_ok) |=> (state_q == ST_OFF));

endmodule

// File: rtl/sleep_seq_outreg.sv
// Module: registered active-low sleep, status and reset outputs.
// Assumes: it is fed the next state, so the outputs change on the same edge as the state.
module sleep_seq_outreg
    import sleep_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  pwr_state_t state_d,
    output logic       deep_sleep_n,
    output logic       s2r_sleep_n,
    output logic       dram_term_sleep_n,
    output logic       susp_stat_n,
    output logic       plat_rst_n,
    output logic       dbg_cpu_rst_n
);

    logic past_s2r, core_up;
    assign past_s2r = (state_d == ST_WAIT_CORE) || (state_d == ST_ON);
    assign core_up  = (state_d == ST_ON);

    // Output flops, all low (asserted) on cold reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            deep_sleep_n      <= 1'b0;
            s2r_sleep_n       <= 1'b0;
            dram_term_sleep_n <= 1'b0;
            susp_stat_n       <= 1'b0;
            plat_rst_n        <= 1'b0;
            dbg_cpu_rst_n     <= 1'b0;
        end else begin
            deep_sleep_n      <= (state_d != ST_OFF);
            s2r_sleep_n       <= past_s2r;
            dram_term_sleep_n <= past_s2r;
            susp_stat_n       <= core_up;
            plat_rst_n        <= core_up;
            dbg_cpu_rst_n     <= core_up;
        end
    end

    // R5: the two memory-side indications move together.
    p_term_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
        s2r_sleep_n == dram_term_sleep_n);

    // R7: the debug reset tracks the platform reset.
    p_dbg_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_cpu_rst_n == plat_rst_n);

endmodule

// File: rtl/sleep_seq_ctrl.sv
// Module: top of the sleep-state handshake controller.
// Assumes: power-good inputs are asynchronous to clk; the requests are synchronous to clk.
module sleep_seq_ctrl
    import sleep_seq_pkg::*;
#(
    parameter int DRAM_CH     = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               soft_off_req,
    input  logic               wake_req,
    input  logic [DRAM_CH-1:0] dram_pg,
    input  logic               core_pg,
    output logic               deep_sleep_n,
    output logic               s2r_sleep_n,
    output logic               dram_term_sleep_n,
    output logic               susp_stat_n,
    output logic               plat_rst_n,
    output logic               dbg_cpu_rst_n,
    output logic [STATE_W-1:0] state_o
);

    localparam int PG_W = DRAM_CH + 1;

    logic [PG_W-1:0] pg_sync_q;
    pwr_state_t      state_q, state_d;

    pg_sync #(.WIDTH(PG_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({core_pg, dram_pg}),
        .dout  (pg_sync_q)
    );

    sleep_seq_fsm #(.DRAM_CH(DRAM_CH)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .soft_off_req (soft_off_req),
        .wake_req     (wake_req),
        .dram_ok      (pg_sync_q[DRAM_CH-1:0]),
        .core_ok      (pg_sync_q[DRAM_CH]),
        .state_q      (state_q),
        .state_d      (state_d)
    );

    sleep_seq_outreg u_out (
        .clk               (clk),
        .rst_n             (rst_n),
        .state_d           (state_d),
        .deep_sleep_n      (deep_sleep_n),
        .s2r_sleep_n       (s2r_sleep_n),
        .dram_term_sleep_n (dram_term_sleep_n),
        .susp_stat_n       (susp_stat_n),
        .plat_rst_n        (plat_rst_n),
        .dbg_cpu_rst_n     (dbg_cpu_rst_n)
    );

    assign state_o = state_q;

    // R1: soft-off shows every output asserted.
    p_off_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_OFF) |-> !(deep_sleep_n | s2r_sleep_n | dram_term_sleep_n
                                  | susp_stat_n | plat_rst_n | dbg_cpu_rst_n));

    // R6: full-on shows reset and suspend status released.
    p_on_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_ON) |-> (plat_rst_n && susp_stat_n && s2r_sleep_n && deep_sleep_n));

endmodule

// File: tb/sleep_seq_ctrl_test.sv
module sleep_seq_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       soft_off_req = 1'b0;
    logic       wake_req = 1'b0;
    logic [1:0] dram_pg = 2'b00;
    logic       core_pg = 1'b0;
    logic       deep_sleep_n, s2r_sleep_n, dram_term_sleep_n;
    logic       susp_stat_n, plat_rst_n, dbg_cpu_rst_n;
    logic [2:0] state_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit started = 0;

    always #10 clk = ~clk;  // 50 MHz

    sleep_seq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .soft_off_req(soft_off_req), .wake_req(wake_req),
        .dram_pg(dram_pg), .core_pg(core_pg), .deep_sleep_n(deep_sleep_n),
        .s2r_sleep_n(s2r_sleep_n), .dram_term_sleep_n(dram_term_sleep_n),
        .susp_stat_n(susp_stat_n), .plat_rst_n(plat_rst_n),
        .dbg_cpu_rst_n(dbg_cpu_rst_n), .state_o(state_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model: power-good history queue gives the delayed view (R8).
    int m_st = 0;
    logic [2:0] hist[$] = '{3'b000, 3'b000};
    always @(posedge clk) begin
        logic [2:0] seen;
        started = 1;
        if (!rst_n) begin
            m_st = 0;
            hist = '{3'b000, 3'b000};
        end else begin
            seen = hist[1];
            case (m_st)
                0: if (!soft_off_req && wake_req) m_st = 1;
                1: if (soft_off_req) m_st = 0; else if (seen[1:0] == 2'b11) m_st = 2;
                2: m_st = soft_off_req ? 0 : 3;
                3: if (soft_off_req) m_st = 0; else if (seen[2]) m_st = 4;
                default: if (soft_off_req || seen[1:0] != 2'b11) m_st = 0;
            endcase
            hist.push_front({core_pg, dram_pg});
            void'(hist.pop_back());
        end
    end

    // Compare every output against the model each cycle.
    always @(negedge clk) begin
        if (started && !done) begin
            chk("R11 state code", state_o, m_st);
            chk("R2 deep_sleep_n", deep_sleep_n, m_st != 0);
            chk("R5 s2r_sleep_n", s2r_sleep_n, m_st >= 3);
            chk("R5 dram_term_sleep_n", dram_term_sleep_n, m_st >= 3);
            chk("R6 susp_stat_n", susp_stat_n, m_st == 4);
            chk("R6 plat_rst_n", plat_rst_n, m_st == 4);
            chk("R7 dbg_cpu_rst_n", dbg_cpu_rst_n, plat_rst_n);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_wake();
        wake_req = 1'b1; cyc(1); wake_req = 1'b0;
    endtask

    task automatic pulse_off();
        soft_off_req = 1'b1; cyc(1); soft_off_req = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        cyc(3);
        chk("R1 reset state", state_o, 0);
        chk("R1 reset outputs", {deep_sleep_n, s2r_sleep_n, dram_term_sleep_n,
                                 susp_stat_n, plat_rst_n, dbg_cpu_rst_n}, 0);
        rst_n = 1'b1;
        cyc(4);
        chk("R2 idle in soft-off", state_o, 0);
        wake_req = 1'b1; soft_off_req = 1'b1; cyc(1);
        wake_req = 1'b0; soft_off_req = 1'b0;
        chk("R2 soft-off request wins", state_o, 0);
        pulse_wake();
        chk("R2 wake leaves soft-off", state_o, 1);
        chk("R2 deep-sleep released", deep_sleep_n, 1);

        dram_pg = 2'b01; cyc(6);
        chk("R3 one channel holds wait", state_o, 1);
        dram_pg = 2'b11; cyc(2);
        chk("R8 not yet after two edges", state_o, 1);
        cyc(1);
        chk("R8 acted on at third edge", state_o, 2);
        chk("R5 s2r still asserted", s2r_sleep_n, 0);
        cyc(1);
        chk("R4 one cycle in suspend-to-RAM", state_o, 3);
        chk("R5 both released together", {s2r_sleep_n, dram_term_sleep_n}, 2'b11);
        chk("R6 reset still held", plat_rst_n, 0);

        core_pg = 1'b1; cyc(2);
        chk("R8 core not yet seen", state_o, 3);
        cyc(1);
        chk("R6 full-on entered", state_o, 4);
        chk("R6 suspend status released", susp_stat_n, 1);
        chk("R7 debug reset released", dbg_cpu_rst_n, 1);
        cyc(4);
        chk("R6 full-on held", state_o, 4);

        dram_pg = 2'b10; cyc(2);
        chk("R8 drop not yet seen", state_o, 4);
        cyc(1);
        chk("R10 DRAM loss to soft-off", state_o, 0);
        chk("R10 platform reset asserted", plat_rst_n, 0);

        dram_pg = 2'b11; cyc(4);
        pulse_wake();
        chk("R2 second wake", state_o, 1);
        cyc(1);
        chk("R3 stable power advances", state_o, 2);
        cyc(1);
        chk("R4 single cycle again", state_o, 3);
        cyc(1);
        chk("R6 on with core good", state_o, 4);
        pulse_off();
        chk("R9 request from full-on", state_o, 0);
        chk("R9 outputs asserted", {deep_sleep_n, s2r_sleep_n, susp_stat_n}, 0);

        dram_pg = 2'b01; cyc(4);
        pulse_wake();
        cyc(2);
        pulse_off();
        chk("R9 request from DRAM wait", state_o, 0);

        core_pg = 1'b0; dram_pg = 2'b11; cyc(4);
        pulse_wake();
        cyc(2);
        chk("R4 reached core wait", state_o, 3);
        cyc(3);
        chk("R6 waits for core power", state_o, 3);
        pulse_off();
        chk("R9 request from core wait", state_o, 0);
        chk("R9 deep-sleep asserted", deep_sleep_n, 0);
        cyc(2);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule